// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt lines and presents one interrupt request to a processor. Each line has its own mode word and vector word. The mode word sets the trigger kind and a 3-bit priority. The vector word holds the value that software reads back when that line wins arbitration. Enable bits are changed through separate set and clear command words, so that no read-modify-write is needed. A mask word reads back the enable state.

Software services an interrupt by reading the vector port. The read returns the vector of the winning source and records its priority on a nesting stack that is eight levels deep. While that level is on top of the stack, only a source of strictly higher priority can raise the request again. Each end-of-interrupt write removes one level from the stack. When no source qualifies, the vector port returns a programmable spurious value and does not touch the stack.

Inputs are synchronised before use. Edge-triggered sources keep a latched pending bit. Active-low and falling-edge triggers are accepted only on sources marked external by a parameter, and on the one fast source.

Top module: `pic_top`

## Requirements
- R1: A write to the enable-set word (word address 66) sets the enable of each source whose data bit is 1. A write to the enable-clear word (address 67) clears the enable of each source whose data bit is 1. Zero bits leave enables as they were. The mask word (address 68) reads the enables, with bit i for source i.
- R2: The mode word of source i is at word address i. It holds the priority in bits [2:0] and the trigger kind in bits [5:4], encoded as 0 high level, 1 rising edge, 2 low level, 3 falling edge. The vector word of source i is at address 32+i. Both words read back what was stored.
- R3: On an internal source, a mode write that asks for kind 2 or 3 leaves the stored trigger kind unchanged and still updates the priority. External sources and the fast source store all four kinds.
- R4: A level source is pending while its synchronised input is at the active level. An edge source latches a pending bit on the selected edge, and the bit stays set after the input returns.
- R5: A write to the pending-clear word (address 69) clears the latched pending bit of each source whose data bit is 1. A vector read that selects an edge source also clears that source's latched bit.
- R6: A vector read (address 64) returns, one cycle later, the vector of the enabled, pending source with the highest priority (7 is highest). Among equal priorities, the lowest index wins.
- R7: When no source qualifies, a vector read returns the spurious word (address 65) and leaves the nesting stack unchanged.
- R8: `irq_out` is high exactly when an enabled, pending source has a priority strictly above the level on top of the stack. When the stack is empty, any enabled, pending source raises it.
- R9: A qualifying vector read pushes the winner's priority onto the stack. A write to address 70 (end of interrupt) pops one level. An end-of-interrupt write on an empty stack does nothing. Eight end-of-interrupt writes empty the stack from any state.
- R10: After reset, all enables are 0, nothing is pending, the stack is empty, `irq_out` is low and the spurious word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two kinds of internal fault show up at the ports. A corrupted stack depth or top level shows as `irq_out` staying low for a source that should interrupt, or firing again at a level that is already active. The bench sees this at the first end-of-interrupt write or vector read after the fault. A wrong arbitration result or a lost pending latch shows at the next vector read, as a wrong vector or as the spurious value. The sweeps of enable patterns and the step-by-step unwinding of the stack are built to expose these faults within a few cycles.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      TRIG_HIGH = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_LOW  = 2'd2,
      TRIG_FALL = 2'd3
   } trig_e;

   localparam int unsigned BUS_AW = 8;
   localparam int unsigned BUS_DW = 32;

   localparam logic [BUS_AW-1:0] A_VECTOR   = 8'd64;
   localparam logic [BUS_AW-1:0] A_SPUR     = 8'd65;
   localparam logic [BUS_AW-1:0] A_EN_SET   = 8'd66;
   localparam logic [BUS_AW-1:0] A_EN_CLR   = 8'd67;
   localparam logic [BUS_AW-1:0] A_MASK     = 8'd68;
   localparam logic [BUS_AW-1:0] A_PEND_CLR = 8'd69;
   localparam logic [BUS_AW-1:0] A_EOI      = 8'd70;

   // bit 0 of the kind selects edge behaviour, bit 1 selects inverted polarity
   function automatic logic trig_is_edge(trig_e t);
      return t[0];
   endfunction

   function automatic logic trig_is_inv(trig_e t);
      return t[1];
   endfunction

endpackage

// File: rtl/pic_src_cond.sv
module pic_src_cond
   import pic_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  raw_in,
   input  trig_e trig,
   input  logic  pend_clr,
   input  logic  svc_ack,
   output logic  pend
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pic_src_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   lvl;
   logic                   active;
   logic                   edge_hit;

   assign lvl = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
         prev_q <= lvl;
      end
   end

   always_comb begin
      active   = trig_is_inv(trig) ? ~lvl : lvl;
      edge_hit = trig_is_inv(trig) ? (prev_q & ~lvl) : (~prev_q & lvl);
   end

   // a new edge wins over a clear in the same cycle so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else if (edge_hit && trig_is_edge(trig)) begin
         latch_q <= 1'b1;
      end else if (pend_clr || svc_ack) begin
         latch_q <= 1'b0;
      end
   end

   assign pend = trig_is_edge(trig) ? latch_q : active;

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
)(
   input  logic [N_SRC-1:0]        cand,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    found,
   output logic [IDX_W-1:0]        win_idx,
   output logic [PRIO_W-1:0]       win_prio
);

   // strict compare keeps the earliest index on a tie
   always_comb begin
      found    = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (cand[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] > win_prio))) begin
            found    = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/pic_lvl_stack.sv
module pic_lvl_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned IXW   = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_lvl,
   input  logic              pop,
   output logic              empty,
   output logic              full,
   output logic [PRIO_W-1:0] top_lvl,
   output logic [CNT_W-1:0]  depth
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pic_lvl_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [PRIO_W-1:0] mem_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  top_ptr;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign top_ptr = cnt_q - CNT_W'(1);
   assign top_lvl = empty ? '0 : mem_q[top_ptr[IXW-1:0]];
   assign depth   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < int'(DEPTH); k++) mem_q[k] <= '0;
      end else if (push && !full) begin
         mem_q[cnt_q[IXW-1:0]] <= push_lvl;
         cnt_q                 <= cnt_q + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/pic_top.sv
module pic_top
   import pic_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned PRIO_W      = 3,
   parameter int unsigned VEC_W       = 32,
   parameter int unsigned STACK_DEPTH = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] EXT_MASK    = 32'hE000_0000,
   parameter int unsigned FAST_IDX    = 0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1);
   localparam logic [NUM_SRC-1:0] LOWSIDE_OK =
      NUM_SRC'(EXT_MASK) | (NUM_SRC'(1) << FAST_IDX);

   generate
      if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_nsrc
         $error("pic_top: NUM_SRC must be in 2..32");
      end
      if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
         $error("pic_top: PRIO_W must be in 1..4");
      end
      if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vec
         $error("pic_top: VEC_W must be in 1..32");
      end
      if (FAST_IDX >= NUM_SRC) begin : g_bad_fast
         $error("pic_top: FAST_IDX out of range");
      end
      if (STACK_DEPTH < (1 << PRIO_W)) begin : g_bad_stack
         $error("pic_top: stack must hold one entry per priority level");
      end
   endgenerate

   // ---------------- bus decode ----------------
   logic       wr_hit, rd_hit;
   logic       sel_mode, sel_vec;
   logic [4:0] reg_idx;

   assign wr_hit   = bus_sel &  bus_wr;
   assign rd_hit   = bus_sel & ~bus_wr;
   assign sel_mode = (bus_addr[7:5] == 3'b000);
   assign sel_vec  = (bus_addr[7:5] == 3'b001);
   assign reg_idx  = bus_addr[4:0];

   // ---------------- per-source state ----------------
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [NUM_SRC*2-1:0]      trig_flat;
   logic [NUM_SRC*VEC_W-1:0]  vec_flat;
   logic [NUM_SRC-1:0]        pend;
   logic [NUM_SRC-1:0]        pclr;
   logic [NUM_SRC-1:0]        svc_ack;
   logic [NUM_SRC-1:0]        en_q;
   logic [NUM_SRC-1:0]        cand;
   logic [VEC_W-1:0]          spur_q;

   logic                      found;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic                      qualify;
   logic                      vec_rd;
   logic                      push;
   logic                      pop;
   logic                      stk_empty;
   logic                      stk_full;
   logic [PRIO_W-1:0]         stk_top;
   logic [CNT_W-1:0]          stk_depth;
   trig_e                     req_trig;

   assign req_trig = trig_e'(bus_wdata[5:4]);

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_src
      logic [PRIO_W-1:0] prio_q;
      trig_e             trig_q;
      logic [VEC_W-1:0]  vec_q;
      logic              hit;

      assign hit = wr_hit && (reg_idx == 5'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q <= '0;
            trig_q <= TRIG_HIGH;
            vec_q  <= '0;
         end else if (hit && sel_mode) begin
            prio_q <= bus_wdata[PRIO_W-1:0];
            if (!trig_is_inv(req_trig) || LOWSIDE_OK[i]) trig_q <= req_trig;
         end else if (hit && sel_vec) begin
            vec_q <= bus_wdata[VEC_W-1:0];
         end
      end

      assign pclr[i]    = wr_hit && (bus_addr == A_PEND_CLR) && bus_wdata[i];
      assign svc_ack[i] = push && (win_idx == IDX_W'(i));

      pic_src_cond #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_cond (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_in   (src_in[i]),
         .trig     (trig_q),
         .pend_clr (pclr[i]),
         .svc_ack  (svc_ack[i]),
         .pend     (pend[i])
      );

      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
      assign trig_flat[i*2 +: 2]           = trig_q;
      assign vec_flat[i*VEC_W +: VEC_W]    = vec_q;
   end

   // ---------------- enables and spurious word ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         spur_q <= '0;
      end else if (wr_hit) begin
         case (bus_addr)
            A_EN_SET: en_q   <= en_q |  bus_wdata[NUM_SRC-1:0];
            A_EN_CLR: en_q   <= en_q & ~bus_wdata[NUM_SRC-1:0];
            A_SPUR:   spur_q <= bus_wdata[VEC_W-1:0];
            default: ;
         endcase
      end
   end

   assign cand = pend & en_q;

   // ---------------- arbitration and nesting ----------------
   pic_prio_pick #(
      .N_SRC  (NUM_SRC),
      .PRIO_W (PRIO_W)
   ) u_pick (
      .cand      (cand),
      .prio_flat (prio_flat),
      .found     (found),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   assign qualify = found && (stk_empty || (win_prio > stk_top));
   assign vec_rd  = rd_hit && (bus_addr == A_VECTOR);
   assign push    = vec_rd && qualify;
   assign pop     = wr_hit && (bus_addr == A_EOI);
   assign irq_out = qualify;

   pic_lvl_stack #(
      .DEPTH  (STACK_DEPTH),
      .PRIO_W (PRIO_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_lvl (win_prio),
      .pop      (pop),
      .empty    (stk_empty),
      .full     (stk_full),
      .top_lvl  (stk_top),
      .depth    (stk_depth)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (sel_mode) begin
         rd_next[PRIO_W-1:0] = prio_flat[int'(reg_idx)*PRIO_W +: PRIO_W];
         rd_next[5:4]        = trig_flat[int'(reg_idx)*2 +: 2];
      end else if (sel_vec) begin
         rd_next[VEC_W-1:0]  = vec_flat[int'(reg_idx)*VEC_W +: VEC_W];
      end else begin
         case (bus_addr)
            A_VECTOR: rd_next[VEC_W-1:0] =
               qualify ? vec_flat[int'(win_idx)*VEC_W +: VEC_W] : spur_q;
            A_SPUR:   rd_next[VEC_W-1:0]   = spur_q;
            A_MASK:   rd_next[NUM_SRC-1:0] = en_q;
            default:  rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_hit) bus_rdata <= rd_next;
   end

endmodule

// File: rtl/pic_top_chk.sv
module pic_top_chk
   import pic_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned VEC_W       = 32,
   parameter int unsigned STACK_DEPTH = 8,
   localparam int unsigned CNT_W      = $clog2(STACK_DEPTH + 1)
)(
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [7:0]         bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] cand,
   input logic [VEC_W-1:0]   spur_q,
   input logic [CNT_W-1:0]   depth
);

   logic wr_set, wr_clr, wr_eoi, vrd;
   assign wr_set = bus_sel && bus_wr  && (bus_addr == A_EN_SET);
   assign wr_clr = bus_sel && bus_wr  && (bus_addr == A_EN_CLR);
   assign wr_eoi = bus_sel && bus_wr  && (bus_addr == A_EOI);
   assign vrd    = bus_sel && !bus_wr && (bus_addr == A_VECTOR);

   p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

   p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

   p_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vrd && !irq_out) |=> ((bus_rdata[VEC_W-1:0] == $past(spur_q)) && $stable(depth)));

   p_irq_cand_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (cand != '0));

   p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(STACK_DEPTH));

   p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vrd && irq_out && (depth < CNT_W'(STACK_DEPTH))) |=> (depth == $past(depth) + CNT_W'(1)));

   p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eoi && (depth == '0)) |=> (depth == '0));

   p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eoi && (depth != '0)) |=> (depth == $past(depth) - CNT_W'(1)));

endmodule

bind pic_top pic_top_chk #(
   .NUM_SRC     (NUM_SRC),
   .VEC_W       (VEC_W),
   .STACK_DEPTH (STACK_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .en_q      (en_q),
   .cand      (cand),
   .spur_q    (spur_q),
   .depth     (stk_depth)
);

// File: tb/pic_top_bench.sv
module pic_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 32;
   localparam logic [31:0] SPUR = 32'h0000_05A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pic_top u_pic_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   function automatic logic [2:0] prio_of(int i);
      return 3'((i*3 + 1) % 8);
   endfunction

   function automatic logic [31:0] vec_of(int i);
      return 32'h100 + 32'(i*3);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      logic [31:0] m;
      int          best;
      logic [2:0]  bp;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      bus_read(8'd68, rd);  chk("R10 mask after reset", rd, 32'h0);
      chk("R10 irq_out after reset", {31'd0, irq_out}, 32'h0);
      bus_read(8'd64, rd);  chk("R10 vector read gives spurious 0", rd, 32'h0);

      // set up modes, vectors and the spurious word
      for (int i = 0; i < NSRC; i++) begin
         bus_write(8'(i), {29'd0, prio_of(i)});
         bus_write(8'(32 + i), vec_of(i));
      end
      bus_write(8'd65, SPUR);
      bus_write(8'd69, 32'hFFFF_FFFF);

      // R2: readback
      bus_read(8'd7, rd);   chk("R2 mode readback src7", rd, {29'd0, prio_of(7)});
      bus_read(8'd22, rd);  chk("R2 mode readback src22", rd, {29'd0, prio_of(22)});
      bus_read(8'd39, rd);  chk("R2 vector readback src7", rd, vec_of(7));
      bus_read(8'd65, rd);  chk("R2 spurious readback", rd, SPUR);

      // R1: set / clear with zero bits untouched
      bus_write(8'd66, 32'h0000_00F0);
      bus_write(8'd66, 32'h0F00_0000);
      bus_write(8'd67, 32'h0000_0030);
      bus_read(8'd68, rd);  chk("R1 mask after set/set/clear", rd, 32'h0F00_00C0);
      bus_write(8'd67, 32'h0000_0000);
      bus_read(8'd68, rd);  chk("R1 zero clear word changes nothing", rd, 32'h0F00_00C0);

      // R6 / R8 sweep: all inputs high, level-high sources
      settle();
      for (int k = 0; k < 96; k++) begin
         if (k < 32) m = 32'h1 << k;
         else        m = 32'(k - 32) * 32'h9E37_79B9 + 32'(k);
         bus_write(8'd67, 32'hFFFF_FFFF);
         bus_write(8'd66, m);
         best = -1; bp = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (m[i] && (best < 0 || prio_of(i) > bp)) begin
               best = i; bp = prio_of(i);
            end
         end
         chk("R8 irq_out with empty stack", {31'd0, irq_out}, {31'd0, best >= 0});
         bus_read(8'd64, rd);
         chk("R6 vector of winner (R7 when none)", rd, (best >= 0) ? vec_of(best) : SPUR);
         if (best >= 0) bus_write(8'd70, 32'h0);
      end

      // R7: nothing enabled
      bus_write(8'd67, 32'hFFFF_FFFF);
      bus_read(8'd64, rd);  chk("R7 spurious with nothing enabled", rd, SPUR);
      chk("R7 irq_out stays low", {31'd0, irq_out}, 32'h0);

      // R3: internal source refuses low/falling kinds
      bus_write(8'd5, 32'h0000_0024);
      bus_read(8'd5, rd);   chk("R3 internal low refused, prio kept", rd, 32'h0000_0004);
      bus_write(8'd5, 32'h0000_0014);
      bus_write(8'd5, 32'h0000_0034);
      bus_read(8'd5, rd);   chk("R3 internal falling refused", rd, 32'h0000_0014);
      bus_write(8'd5, 32'h0000_0000);

      // R4 / R5: falling edge on external source 31
      bus_write(8'd31, 32'h0000_0036);
      bus_read(8'd31, rd);  chk("R3 external falling accepted", rd, 32'h0000_0036);
      bus_write(8'd69, 32'hFFFF_FFFF);
      bus_write(8'd66, 32'h8000_0000);
      chk("R4 no edge no pending", {31'd0, irq_out}, 32'h0);
      src_in[31] = 1'b0; settle();
      chk("R4 falling edge latches", {31'd0, irq_out}, 32'h1);
      src_in[31] = 1'b1; settle();
      chk("R4 latch holds after input returns", {31'd0, irq_out}, 32'h1);
      bus_write(8'd69, 32'h8000_0000);
      chk("R5 pending clear drops latch", {31'd0, irq_out}, 32'h0);
      src_in[31] = 1'b0; settle();
      chk("R4 second falling edge", {31'd0, irq_out}, 32'h1);
      bus_read(8'd64, rd);  chk("R6 edge source vector", rd, vec_of(31));
      chk("R8 irq_out low after service", {31'd0, irq_out}, 32'h0);
      bus_write(8'd70, 32'h0);
      chk("R5 vector read cleared edge latch", {31'd0, irq_out}, 32'h0);
      src_in[31] = 1'b1;
      bus_write(8'd67, 32'hFFFF_FFFF);

      // R4: low level on the fast source 0
      bus_write(8'd0, 32'h0000_0022);
      bus_read(8'd0, rd);   chk("R3 fast source low accepted", rd, 32'h0000_0022);
      bus_write(8'd66, 32'h0000_0001);
      settle();
      chk("R4 low level inactive when high", {31'd0, irq_out}, 32'h0);
      src_in[0] = 1'b0; settle();
      chk("R4 low level active when low", {31'd0, irq_out}, 32'h1);
      bus_read(8'd64, rd);  chk("R6 fast source vector", rd, vec_of(0));
      chk("R8 same level does not re-raise", {31'd0, irq_out}, 32'h0);
      bus_write(8'd70, 32'h0);
      chk("R9 pop re-exposes level source", {31'd0, irq_out}, 32'h1);
      src_in[0] = 1'b1; settle();
      chk("R4 low level released", {31'd0, irq_out}, 32'h0);
      bus_write(8'd67, 32'hFFFF_FFFF);

      // R4 / R5: rising edge on internal source 3
      bus_write(8'd3, 32'h0000_0015);
      src_in[3] = 1'b0; settle();
      bus_write(8'd69, 32'hFFFF_FFFF);
      bus_write(8'd66, 32'h0000_0008);
      chk("R4 rising idle", {31'd0, irq_out}, 32'h0);
      src_in[3] = 1'b1; settle();
      chk("R4 rising edge latches", {31'd0, irq_out}, 32'h1);
      src_in[3] = 1'b0; settle();
      chk("R4 rising latch holds", {31'd0, irq_out}, 32'h1);
      bus_write(8'd69, 32'h0000_0008);
      chk("R5 clear rising latch", {31'd0, irq_out}, 32'h0);
      src_in[3] = 1'b1; settle();
      bus_write(8'd3, 32'h0000_0000);
      bus_write(8'd67, 32'hFFFF_FFFF);

      // R8 / R9: fill the stack with levels 0..7 from sources 8..15
      for (int j = 0; j < 8; j++) bus_write(8'(8 + j), 32'(j));
      settle();
      for (int j = 0; j < 8; j++) begin
         bus_write(8'd66, 32'h1 << (8 + j));
         chk("R8 higher level raises irq", {31'd0, irq_out}, 32'h1);
         bus_read(8'd64, rd);
         chk("R9 nested vector", rd, vec_of(8 + j));
         chk("R8 irq low at top level", {31'd0, irq_out}, 32'h0);
      end
      bus_read(8'd64, rd);  chk("R7 full nest returns spurious", rd, SPUR);
      bus_write(8'd67, 32'hFFFF_FFFF);
      bus_write(8'd66, 32'h0000_0100);
      for (int k = 1; k <= 8; k++) begin
         bus_write(8'd70, 32'h0);
         chk("R9 unwind step", {31'd0, irq_out}, {31'd0, k == 8});
      end
      for (int k = 0; k < 3; k++) bus_write(8'd70, 32'h0);
      chk("R9 extra pops leave irq", {31'd0, irq_out}, 32'h1);
      bus_read(8'd64, rd);  chk("R9 vector after empty pops", rd, vec_of(8));
      chk("R9 one level pushed", {31'd0, irq_out}, 32'h0);
      bus_write(8'd70, 32'h0);
      chk("R9 single pop empties", {31'd0, irq_out}, 32'h1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule